// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives five divided waveforms from one reference. Every channel has its own high-time count, low-time count, phase offset, start level, force bit and sync-ignore bit. A shared sync input realigns every channel that does not ignore it. After sync is released, each such channel waits out its phase offset and then runs its high/low sequence from its chosen start level.

A front-end selector picks one of two reference sources and honours three power-down bits: one for each source and one for both. The whole block runs on a single core clock. Each reference is presented as a one-cycle strobe marking its input-clock periods, and the selected, live strobe is the clock enable of every divider. Each output is registered. Its value after a core edge is the level the channel held during the input cycle that edge processed.

Top module: `duty_clk_divider`

## Requirements
- R1: While `rst_n` is low every output is 0. At the first core edge after reset release each output shows its channel's start level, and the channel then behaves as if sync had just been released.
- R2: A high count N gives N+1 input cycles of high output, and a low count M gives M+1 cycles of low output. A count of zero still gives a one-cycle phase.
- R3: With start level 1 the waveform after alignment begins with its high phase. With start level 0 it begins with its low phase.
- R4: While `sync_i` is 1, every channel whose sync-ignore bit is 0 shows its start level from the next core edge, and its counters are reloaded.
- R5: With phase offset P, the first P input cycles after sync release show the start level. The start-level phase of the programmed length begins on input cycle P+1.
- R6: A channel whose sync-ignore bit is 1 keeps running unchanged while `sync_i` is asserted.
- R7: A force bit holds the output at the start level only when that channel's sync-ignore bit is also 1. A force bit alone has no effect on the waveform.
- R8: A change to a high or low count while the channel is running leaves the current phase at its old length. The new count first applies to the next phase that uses it.
- R9: `src_sel_i`=1 clocks the dividers from strobe `tick_a_i`, and 0 clocks them from `tick_b_i`.
- R10: When the selected source's power-down bit or `pd_all_i` is 1, every output shows its start level from the next core edge and the dividers do not advance. Powering down only the unselected source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a_i | input | 1 | Period strobe of reference source A |
| tick_b_i | input | 1 | Period strobe of reference source B |
| src_sel_i | input | 1 | 1 selects source A, 0 selects source B |
| pd_a_i | input | 1 | Power-down of source A |
| pd_b_i | input | 1 | Power-down of source B |
| pd_all_i | input | 1 | Power-down of both sources |
| sync_i | input | 1 | Shared alignment request, active high |
| cfg_high_i | input | NCH*CNT_W | High counts, channel k in bits [k*CNT_W +: CNT_W] |
| cfg_low_i | input | NCH*CNT_W | Low counts, same packing |
| cfg_phase_i | input | NCH*CNT_W | Phase offsets, same packing |
| cfg_start_i | input | NCH | Start level, bit k for channel k |
| cfg_force_i | input | NCH | Force to start level, bit k for channel k |
| cfg_nosync_i | input | NCH | Ignore sync, bit k for channel k |
| div_o | output | NCH | Divided outputs, bit k for channel k |

## Verification
The hardest case to reach is a count change that lands in the middle of a running phase. To get there, the stimulus aligns a channel with a sync pulse and follows it input cycle by input cycle. It rewrites the high count during the second cycle of a four-cycle high phase, then compares the complete sequence against one where the old length finishes before the new one applies. Phase offsets are checked the same way against a sequence computed from the counts. Three channels with different offsets and lengths are released from a single sync.

// File: rtl/divclk_pkg.sv
package divclk_pkg;
  typedef enum logic [1:0] {
    CH_LOAD  = 2'd0,
    CH_DELAY = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/divclk_src_sel.sv
module divclk_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_a_i,
  input  logic tick_b_i,
  input  logic src_sel_i,
  input  logic pd_a_i,
  input  logic pd_b_i,
  input  logic pd_all_i,
  output logic live_o,
  output logic tick_o
);
  logic sel_pd;
  logic sel_tick;

  always_comb begin
    sel_pd   = src_sel_i ? pd_a_i : pd_b_i;
    sel_tick = src_sel_i ? tick_a_i : tick_b_i;
    live_o   = ~(sel_pd | pd_all_i);
    tick_o   = live_o & sel_tick;
  end

  assert_dead_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_all_i || (src_sel_i && pd_a_i) || (!src_sel_i && pd_b_i)) |-> !tick_o);
  assert_unsel_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i && !pd_a_i && !pd_all_i && pd_b_i) |-> (tick_o == tick_a_i));
endmodule

// File: rtl/divclk_channel.sv
module divclk_channel
  import divclk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             live_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             start_i,
  input  logic             force_i,
  input  logic             nosync_i,
  output logic             out_o
);
  ch_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             lvl_q, lvl_d;
  logic             out_d;
  logic             sync_eff, force_eff, hold;

  always_comb begin
    sync_eff  = sync_i & ~nosync_i;
    force_eff = force_i & nosync_i;
    hold      = ~live_i | sync_eff | force_eff | (st_q == CH_LOAD);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lim_d = lim_q;
    lvl_d = lvl_q;
    if ((st_q == CH_LOAD) || sync_eff) begin
      st_d  = CH_DELAY;
      cnt_d = phase_i;
      lvl_d = start_i;
      lim_d = start_i ? high_i : low_i;
    end else if (tick_i) begin
      if ((st_q == CH_DELAY) && (cnt_q != '0)) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        st_d = CH_RUN;
        if (cnt_q == lim_q) begin
          lvl_d = ~lvl_q;
          cnt_d = '0;
          lim_d = lvl_q ? low_i : high_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    out_d = hold ? start_i : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_LOAD;
      cnt_q <= '0;
      lim_q <= '0;
      lvl_q <= 1'b0;
      out_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      lvl_q <= lvl_d;
      out_o <= out_d;
    end
  end

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !nosync_i) |=> (out_o == $past(start_i)));
  assert_force_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && nosync_i) |=> (out_o == $past(start_i)));
  assert_pd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !live_i |=> (out_o == $past(start_i)));
  assert_pd_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_i && !sync_eff && (st_q != CH_LOAD)) |=> ($stable(cnt_q) && $stable(lvl_q)));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN) |-> (cnt_q <= lim_q));
endmodule

// File: rtl/duty_clk_divider.sv
module duty_clk_divider #(
  parameter int NCH   = 5,
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_a_i,
  input  logic                 tick_b_i,
  input  logic                 src_sel_i,
  input  logic                 pd_a_i,
  input  logic                 pd_b_i,
  input  logic                 pd_all_i,
  input  logic                 sync_i,
  input  logic [NCH*CNT_W-1:0] cfg_high_i,
  input  logic [NCH*CNT_W-1:0] cfg_low_i,
  input  logic [NCH*CNT_W-1:0] cfg_phase_i,
  input  logic [NCH-1:0]       cfg_start_i,
  input  logic [NCH-1:0]       cfg_force_i,
  input  logic [NCH-1:0]       cfg_nosync_i,
  output logic [NCH-1:0]       div_o
);
  logic live;
  logic tick;

  divclk_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_a_i  (tick_a_i),
    .tick_b_i  (tick_b_i),
    .src_sel_i (src_sel_i),
    .pd_a_i    (pd_a_i),
    .pd_b_i    (pd_b_i),
    .pd_all_i  (pd_all_i),
    .live_o    (live),
    .tick_o    (tick)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    divclk_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .live_i   (live),
      .sync_i   (sync_i),
      .high_i   (cfg_high_i[k*CNT_W +: CNT_W]),
      .low_i    (cfg_low_i[k*CNT_W +: CNT_W]),
      .phase_i  (cfg_phase_i[k*CNT_W +: CNT_W]),
      .start_i  (cfg_start_i[k]),
      .force_i  (cfg_force_i[k]),
      .nosync_i (cfg_nosync_i[k]),
      .out_o    (div_o[k])
    );
  end
endmodule

// File: tb/duty_clk_divider_tb.sv
`timescale 1ns/1ps
module duty_clk_divider_tb_top;
  localparam int NCH = 5;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_a = 1'b1, tick_b = 1'b0, sel = 1'b1;
  logic pd_a = 1'b0, pd_b = 1'b0, pd_all = 1'b0, sync = 1'b0;
  logic [NCH*CW-1:0] c_high = '0, c_low = '0, c_phase = '0;
  logic [NCH-1:0] c_start = '0, c_force = '0, c_nosync = '0;
  logic [NCH-1:0] dout;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  duty_clk_divider #(.NCH(NCH), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .src_sel_i(sel), .pd_a_i(pd_a), .pd_b_i(pd_b), .pd_all_i(pd_all),
    .sync_i(sync), .cfg_high_i(c_high), .cfg_low_i(c_low),
    .cfg_phase_i(c_phase), .cfg_start_i(c_start), .cfg_force_i(c_force),
    .cfg_nosync_i(c_nosync), .div_o(dout));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_ch(input int k, input int h, input int l, input int p,
                        input logic s, input logic f, input logic n);
    c_high[k*CW +: CW]  = CW'(h);
    c_low[k*CW +: CW]   = CW'(l);
    c_phase[k*CW +: CW] = CW'(p);
    c_start[k]  = s;
    c_force[k]  = f;
    c_nosync[k] = n;
  endtask

  function automatic logic exp_lvl(input int k, input int p, input int h,
                                   input int l, input logic s);
    int m, first;
    if (k <= p) return s;
    m = (k - p - 1) % (h + l + 2);
    first = s ? h + 1 : l + 1;
    return (m < first) ? s : ~s;
  endfunction

  task automatic pulse_sync(input int n);
    sync = 1'b1;
    repeat (n) step();
    sync = 1'b0;
  endtask

  // R1: reset value and first edge after release
  task automatic t_reset();
    set_ch(0, 2, 1, 0, 1'b0, 1'b0, 1'b0);
    set_ch(1, 0, 0, 3, 1'b1, 1'b0, 1'b0);
    set_ch(2, 5, 3, 7, 1'b1, 1'b0, 1'b0);
    set_ch(3, 1, 1, 0, 1'b0, 1'b0, 1'b1);
    set_ch(4, 0, 0, 0, 1'b1, 1'b0, 1'b0);
    #1;
    check(dout == '0, "R1 reset value", int'(dout), 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    check(dout == c_start, "R1 start level after reset", int'(dout), int'(c_start));
  endtask

  // R2 R3 R4 R5: aligned waveforms with several offsets and lengths
  task automatic t_wave();
    int bad[3];
    int ph[3] = '{0, 3, 7};
    int hi[3] = '{2, 0, 5};
    int lo[3] = '{1, 0, 3};
    logic st[3] = '{1'b0, 1'b1, 1'b1};
    sync = 1'b1;
    step();
    check(dout[2:0] == 3'b110, "R4 start level during sync", int'(dout[2:0]), 6);
    step(); step();
    sync = 1'b0;
    for (int c = 0; c < 3; c++) bad[c] = 0;
    for (int k = 1; k <= 40; k++) begin
      step();
      for (int c = 0; c < 3; c++)
        if (dout[c] !== exp_lvl(k, ph[c], hi[c], lo[c], st[c])) bad[c]++;
    end
    check(bad[0] == 0, "R2 R3 ch0 start low H=2 L=1", bad[0], 0);
    check(bad[1] == 0, "R2 R5 ch1 zero counts offset 3", bad[1], 0);
    check(bad[2] == 0, "R5 R3 ch2 offset 7 start high", bad[2], 0);
  endtask

  // R6: sync-ignoring channel keeps toggling through sync
  task automatic t_nosync();
    int tr = 0;
    logic prev = dout[3];
    sync = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      if (dout[3] != prev) tr++;
      prev = dout[3];
      check(dout[0] == 1'b0, "R4 ch0 held during sync", int'(dout[0]), 0);
    end
    sync = 1'b0;
    check(tr > 0, "R6 nosync channel kept running", tr, 1);
  endtask

  // R7: force ignored without nosync, holds with nosync
  task automatic t_force();
    int tr = 0, bad = 0;
    logic prev;
    set_ch(4, 0, 0, 0, 1'b1, 1'b1, 1'b0);
    pulse_sync(2);
    prev = dout[4];
    for (int i = 0; i < 6; i++) begin
      step();
      if (dout[4] != prev) tr++;
      prev = dout[4];
    end
    check(tr >= 4, "R7 force without nosync has no effect", tr, 5);
    c_nosync[4] = 1'b1;
    step();
    for (int i = 0; i < 8; i++) begin
      step();
      if (dout[4] !== 1'b1) bad++;
    end
    check(bad == 0, "R7 force with nosync holds start", bad, 0);
    set_ch(4, 0, 0, 0, 1'b1, 1'b0, 1'b0);
  endtask

  // R8: count change mid-phase applies at the next boundary
  task automatic t_count_change();
    logic [9:0] seq;
    logic [9:0] want = 10'b1001001111;
    set_ch(0, 3, 1, 0, 1'b1, 1'b0, 1'b0);
    pulse_sync(2);
    for (int k = 1; k <= 10; k++) begin
      step();
      seq[k-1] = dout[0];
      if (k == 2) c_high[0 +: CW] = CW'(0);
    end
    check(seq == want, "R8 count change at phase boundary", int'(seq), int'(want));
  endtask

  // R10: power-down behaviour
  task automatic t_powerdown();
    int bad = 0, tr = 0;
    logic prev;
    pd_all = 1'b1;
    step();
    for (int i = 0; i < 5; i++) begin
      step();
      if (dout !== c_start) bad++;
    end
    check(bad == 0, "R10 pd_all holds start levels", bad, 0);
    pd_all = 1'b0; pd_a = 1'b1; bad = 0;
    step();
    for (int i = 0; i < 5; i++) begin
      step();
      if (dout !== c_start) bad++;
    end
    check(bad == 0, "R10 selected source powered down", bad, 0);
    pd_a = 1'b0; pd_b = 1'b1;
    pulse_sync(1);
    prev = dout[1];
    for (int i = 0; i < 12; i++) begin
      step();
      if (dout[1] != prev) tr++;
      prev = dout[1];
    end
    check(tr >= 8, "R10 unselected power-down has no effect", tr, 9);
    pd_b = 1'b0;
  endtask

  // R9: source B selected, strobe on alternate core cycles
  task automatic t_src_b();
    int tr = 0;
    logic prev;
    sel = 1'b0;
    set_ch(4, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    pulse_sync(1);
    prev = dout[4];
    for (int i = 0; i < 20; i++) begin
      tick_b = ~tick_b;
      step();
      if (dout[4] != prev) tr++;
      prev = dout[4];
    end
    check(tr >= 9 && tr <= 10, "R9 source B strobe clocks dividers", tr, 10);
    tick_b = 1'b0; tr = 0;
    prev = dout[4];
    for (int i = 0; i < 8; i++) begin
      step();
      if (dout[4] != prev) tr++;
      prev = dout[4];
    end
    check(tr == 0, "R9 source A ignored when B selected", tr, 0);
    sel = 1'b1;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_wave();
        t_nosync();
        t_force();
        t_count_change();
        t_powerdown();
        t_src_b();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule